// File: doc/BRIEF.md
# Serial Slave Memory Access Port

This block lets an external SPI host read and write a byte-wide local data memory. The host frames each transfer with an active-low select. The first byte is a command. For the two memory commands, a 16-bit address follows, and then any number of data bytes. Each data byte moves to the next address. A write stores every complete byte that arrives. A read fetches the first byte as soon as the address is complete, then prefetches each following byte while the current one shifts out.

Any other command value is a command-only transfer. The port records it and ignores the rest of the frame. The most recent command, and the most recent memory address, stay visible to the local processor in two registers.

All three SPI inputs are brought into the system clock through two-flop synchronizers, and serial clock edges are found there. The system clock must run at least eight times faster than the serial clock. An enable input gates the whole port. The serial output is given as a data bit plus an output-enable, which a pad cell turns into a three-state pin.

Top module: `spi_mem_port`

## Requirements
- R1: While `spi_csn` is high the output enable is low, and serial clock and data activity causes no memory access and no register change.
- R2: While `port_en` is low the output enable is low, no memory access is issued, and the command and address registers do not change.
- R3: For command 0x01, each complete data byte is written once to the current address. Data bits arrive MSB first and are sampled on rising serial clock edges.
- R4: After each data byte the address advances by one, so a multi-byte transfer covers consecutive locations.
- R5: For command 0x02, the byte at the frame address is fetched when the last address bit arrives. Following bytes come from consecutive addresses. Each byte is shifted out MSB first, and the output changes on falling serial clock edges.
- R6: Both registers reset to zero. `last_cmd` takes the command after its 8th bit. `last_addr` takes the address after its 16th bit, for commands 0x01 and 0x02 only.
- R7: Any other command ends the useful part of the frame after its 8th bit: `last_cmd` updates, while `last_addr` and the memory are left untouched.
- R8: Raising `spi_csn` ends the frame at any bit. A partial data byte is discarded, and the next frame starts again at the command byte.
- R9: While `port_en` is high and `spi_csn` is low, the output enable is high.
- R10: The address wraps from 0xFFFF to 0x0000 during a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable |
| spi_csn | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_re | output | 1 | Memory read strobe; data expected one cycle later |
| mem_rdata | input | 8 | Memory read data |
| last_cmd | output | 8 | Most recent command byte |
| last_addr | output | 16 | Most recent memory-command address |

## Verification
The hardest states to reach are the frame boundaries. These are a select release partway through a data byte, a release partway through the address, and a burst that crosses the top of the address space. The bench builds its frames bit by bit with a shift task that can stop after any number of bits. This lets it release the select at exactly those points and then confirm, through the write strobes and the captured registers, that a fresh frame is decoded correctly. Read data returned by the bench memory was written through the port earlier. This closes the loop on bit order in both directions.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int CMD_W = 8;
    localparam logic [CMD_W-1:0] CMD_WRITE = 8'h01;
    localparam logic [CMD_W-1:0] CMD_READ  = 8'h02;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_t;

    function automatic logic is_mem_cmd(input logic [CMD_W-1:0] c);
        return (c == CMD_WRITE) || (c == CMD_READ);
    endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain[s] <= din;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              sclk_s,
    input  logic              mosi_s,
    output logic              miso_bit,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CMD_W-1:0]  last_cmd,
    output logic [ADDR_W-1:0] last_addr
);
    localparam int CNT_W = $clog2(ADDR_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    phase_t            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-2:0] rx_sr;
    logic [ADDR_W-1:0] rx_next;
    logic [DATA_W-1:0] tx_sr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              miso_q;
    logic              fetch_pend;
    logic              sclk_d;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              cmd_done;
    logic              addr_done;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    always_comb begin
        sclk_rise = active &  sclk_s & ~sclk_d;
        sclk_fall = active & ~sclk_s &  sclk_d;
        rx_next   = {rx_sr, mosi_s};
        cmd_done  = sclk_rise && (phase == PH_CMD)  && (bit_cnt == CMD_LAST);
        addr_done = sclk_rise && (phase == PH_ADDR) && (bit_cnt == ADDR_LAST);
    end

    // framing, shifting and memory strobes; cleared whenever deselected
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase      <= PH_CMD;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            miso_q     <= 1'b0;
            mem_we     <= 1'b0;
            mem_re     <= 1'b0;
            fetch_pend <= 1'b0;
        end else begin
            mem_we     <= 1'b0;
            mem_re     <= 1'b0;
            fetch_pend <= mem_re;
            if (mem_we) addr_q <= addr_q + 1'b1;
            if (sclk_fall) begin
                miso_q <= tx_sr[DATA_W-1];
                tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
            end
            if (fetch_pend) tx_sr <= mem_rdata;
            if (sclk_rise) begin
                rx_sr   <= rx_next[ADDR_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                case (phase)
                    PH_CMD: if (bit_cnt == CMD_LAST) begin
                        bit_cnt <= '0;
                        phase   <= is_mem_cmd(rx_next[CMD_W-1:0]) ? PH_ADDR : PH_SKIP;
                    end
                    PH_ADDR: if (bit_cnt == ADDR_LAST) begin
                        bit_cnt <= '0;
                        phase   <= PH_DATA;
                        addr_q  <= rx_next;
                        mem_re  <= (last_cmd == CMD_READ);
                    end
                    PH_DATA: if (bit_cnt == DATA_LAST) begin
                        bit_cnt <= '0;
                        if (last_cmd == CMD_WRITE) begin
                            mem_we  <= 1'b1;
                            wdata_q <= rx_next[DATA_W-1:0];
                        end else begin
                            addr_q <= addr_q + 1'b1;
                            mem_re <= 1'b1;
                        end
                    end
                    default: bit_cnt <= '0;
                endcase
            end
        end
    end

    // captured command and address survive deselection
    always_ff @(posedge clk) begin
        if (rst) begin
            last_cmd  <= '0;
            last_addr <= '0;
        end else begin
            if (cmd_done)  last_cmd  <= rx_next[CMD_W-1:0];
            if (addr_done) last_addr <= rx_next;
        end
    end

    assign miso_bit  = miso_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
endmodule

// File: rtl/spi_mem_port.sv
module spi_mem_port
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CMD_W-1:0]  last_cmd,
    output logic [ADDR_W-1:0] last_addr
);
    logic [2:0] pins_s;
    logic       active;
    logic       miso_bit;

    spi_mem_sync #(
        .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({spi_csn, spi_sclk, spi_mosi}),
        .dout(pins_s)
    );

    assign active = port_en & ~pins_s[2];

    spi_mem_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .sclk_s   (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .miso_bit (miso_bit),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .mem_rdata(mem_rdata),
        .last_cmd (last_cmd),
        .last_addr(last_addr)
    );

    assign spi_miso_oe = active;
    assign spi_miso    = active & miso_bit;
endmodule

// File: rtl/spi_mem_port_chk.sv
module spi_mem_port_chk
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              port_en,
    input logic              spi_csn,
    input logic              spi_miso_oe,
    input logic              mem_we,
    input logic              mem_re,
    input logic [CMD_W-1:0]  last_cmd,
    input logic [ADDR_W-1:0] last_addr
);
    p_hiz_deselect_r1: assert property (@(posedge clk) disable iff (rst)
        spi_csn && $past(spi_csn) && $past(spi_csn, 2) |-> !spi_miso_oe);

    p_off_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        !port_en |-> !spi_miso_oe);

    p_off_no_access_r2: assert property (@(posedge clk) disable iff (rst)
        !port_en && !$past(port_en) |-> !mem_we && !mem_re);

    p_write_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> last_cmd == CMD_WRITE);

    p_read_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> last_cmd == CMD_READ);

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    p_addr_only_mem_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(last_addr) |-> (last_cmd == CMD_WRITE) || (last_cmd == CMD_READ));

    p_drive_selected_r9: assert property (@(posedge clk) disable iff (rst)
        port_en && !spi_csn && !$past(spi_csn) && !$past(spi_csn, 2) |-> spi_miso_oe);
endmodule

bind spi_mem_port spi_mem_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .port_en    (port_en),
    .spi_csn    (spi_csn),
    .spi_miso_oe(spi_miso_oe),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .last_cmd   (last_cmd),
    .last_addr  (last_addr)
);

// File: tb/spi_mem_port_bench.sv
module spi_mem_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b0;
    logic        spi_csn = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  last_cmd;
    logic [15:0] last_addr;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0]  mem_model [256];
    logic [15:0] wr_addr_log [16];
    logic [7:0]  wr_data_log [16];
    int          wr_cnt = 0;

    always #10 clk = ~clk;

    spi_mem_port u_spi_mem_port (
        .clk(clk), .rst(rst), .port_en(port_en),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .last_cmd(last_cmd), .last_addr(last_addr)
    );

    // synchronous memory model with a write log
    always @(posedge clk) begin
        if (mem_we) begin
            mem_model[mem_addr[7:0]] <= mem_wdata;
            if (wr_cnt < 16) begin
                wr_addr_log[wr_cnt] <= mem_addr;
                wr_data_log[wr_cnt] <= mem_wdata;
            end
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_re) mem_rdata <= mem_model[mem_addr[7:0]];
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift n bits MSB first from tx; returns bits seen on miso
    task automatic spi_shift(input int n, input logic [7:0] tx, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            wait_clk(8);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            wait_clk(8);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [7:0] dummy;
        spi_shift(8, b, dummy);
    endtask

    task automatic cs_begin();
        spi_csn = 1'b0;
        wait_clk(4);
    endtask

    task automatic cs_end();
        wait_clk(4);
        spi_csn = 1'b1;
        wait_clk(8);
    endtask

    task automatic t_reset();
        check("R6", "last_cmd after reset", last_cmd, 0);
        check("R6", "last_addr after reset", last_addr, 0);
        check("R1", "oe while deselected", spi_miso_oe, 0);
        port_en = 1'b1;
        for (int k = 0; k < 3; k++) send_byte(8'h01);
        wait_clk(6);
        check("R1", "writes with select high", wr_cnt, 0);
        check("R1", "last_cmd with select high", last_cmd, 0);
        check("R1", "oe after activity, deselected", spi_miso_oe, 0);
    endtask

    task automatic t_disabled();
        port_en = 1'b0;
        cs_begin();
        check("R2", "oe while disabled", spi_miso_oe, 0);
        send_byte(8'h01); send_byte(8'h00); send_byte(8'h10); send_byte(8'hAA);
        cs_end();
        check("R2", "writes while disabled", wr_cnt, 0);
        check("R2", "last_cmd while disabled", last_cmd, 0);
        check("R2", "last_addr while disabled", last_addr, 0);
        port_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic t_write_single();
        cs_begin();
        check("R9", "oe while selected", spi_miso_oe, 1);
        send_byte(8'h01); send_byte(8'h12); send_byte(8'h34); send_byte(8'hC3);
        cs_end();
        check("R3", "write count", wr_cnt, 1);
        check("R3", "write address", wr_addr_log[0], 16'h1234);
        check("R3", "write data MSB first", wr_data_log[0], 8'hC3);
        check("R6", "last_cmd write", last_cmd, 8'h01);
        check("R6", "last_addr write", last_addr, 16'h1234);
        check("R1", "oe after release", spi_miso_oe, 0);
    endtask

    task automatic t_write_burst();
        cs_begin();
        send_byte(8'h01); send_byte(8'h00); send_byte(8'h40);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        cs_end();
        check("R4", "burst write count", wr_cnt, 4);
        check("R4", "burst addr 0", wr_addr_log[1], 16'h0040);
        check("R4", "burst addr 1", wr_addr_log[2], 16'h0041);
        check("R4", "burst addr 2", wr_addr_log[3], 16'h0042);
        check("R4", "burst data 2", wr_data_log[3], 8'h33);
    endtask

    task automatic t_wrap();
        cs_begin();
        send_byte(8'h01); send_byte(8'hFF); send_byte(8'hFF);
        send_byte(8'h5A); send_byte(8'hA5);
        cs_end();
        check("R10", "wrap write count", wr_cnt, 6);
        check("R10", "addr before wrap", wr_addr_log[4], 16'hFFFF);
        check("R10", "addr after wrap", wr_addr_log[5], 16'h0000);
        check("R10", "data after wrap", wr_data_log[5], 8'hA5);
    endtask

    task automatic t_read();
        logic [7:0] rx;
        cs_begin();
        send_byte(8'h02); send_byte(8'h00); send_byte(8'h40);
        spi_shift(8, 8'h00, rx); check("R5", "read byte 0", rx, 8'h11);
        spi_shift(8, 8'h00, rx); check("R5", "read byte 1", rx, 8'h22);
        spi_shift(8, 8'h00, rx); check("R5", "read byte 2", rx, 8'h33);
        cs_end();
        check("R6", "last_cmd read", last_cmd, 8'h02);
        check("R6", "last_addr read", last_addr, 16'h0040);
        check("R5", "no writes during read", wr_cnt, 6);
        cs_begin();
        send_byte(8'h02); send_byte(8'h12); send_byte(8'h34);
        spi_shift(8, 8'h00, rx); check("R5", "read bit order", rx, 8'hC3);
        cs_end();
    endtask

    task automatic t_cmd_only();
        cs_begin();
        send_byte(8'h5A); send_byte(8'h01); send_byte(8'h00); send_byte(8'h99);
        cs_end();
        check("R7", "last_cmd other", last_cmd, 8'h5A);
        check("R7", "last_addr kept", last_addr, 16'h1234);
        check("R7", "no writes", wr_cnt, 6);
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        cs_begin();
        send_byte(8'h01); send_byte(8'h00); send_byte(8'h70);
        spi_shift(4, 8'hF0, rx);
        cs_end();
        check("R8", "partial byte discarded", wr_cnt, 6);
        check("R8", "address taken before abort", last_addr, 16'h0070);
        cs_begin();
        send_byte(8'h01); send_byte(8'h00); send_byte(8'h71); send_byte(8'h3C);
        cs_end();
        check("R8", "fresh frame write count", wr_cnt, 7);
        check("R8", "fresh frame address", wr_addr_log[6], 16'h0071);
        check("R8", "fresh frame data", wr_data_log[6], 8'h3C);
        cs_begin();
        send_byte(8'h01); send_byte(8'h08);
        cs_end();
        check("R8", "abort in address keeps last_addr", last_addr, 16'h0071);
        check("R8", "abort in address writes", wr_cnt, 7);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_disabled();
        t_write_single();
        t_write_burst();
        t_wrap();
        t_read();
        t_cmd_only();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule